// File: doc/BRIEF.md
# Three-Digit Decimal Incrementor

This block adds one to a packed binary-coded decimal number of three digits held in a 12-bit word. It is purely combinational. Each 4-bit field carries one decimal digit in 8421 weighting, and the hundreds digit sits in the top nibble. The sum is formed by a chain of identical single-digit stages. The units stage always receives an increment request. Each higher stage sees only the decimal carry from the stage below it. The carry never ripples as a binary carry across the whole word.

A typical use is a decimal event counter or a display value that is bumped by one. The surrounding logic registers the result and feeds it back. The carry from the hundreds stage reports that 999 rolled over to 000.

A field holding a code above nine is illegal. The stage that holds it outputs zero and asserts its carry in every case, so even malformed input gives a known, legal result.

Top module: `bcdinc_word`

## Requirements
- R1: For every legal input, with each field 0 to 9 and the value read as hundreds*100 + tens*10 + units from fields [11:8], [7:4] and [3:0], `bcd_out` holds (value + 1) mod 1000 in the same field layout.
- R2: Input 0x259 (decimal 259) produces output 0x260, with `carry_out` low.
- R3: Input 0x999 produces output 0x000, with `carry_out` high.
- R4: For every legal input other than 0x999, `carry_out` is low.
- R5: A digit whose stage receives no carry from below passes to the output unchanged. For example, input 0x120 gives 0x121, with the tens and hundreds fields unchanged.
- R6: A field holding 1010 to 1111 is illegal. Its stage outputs 0000 and asserts its carry, whether or not a carry arrived from below. That carry increments the next higher digit. When the hundreds field is illegal, the carry appears on `carry_out`.
- R7: Every output field is always a legal digit (0 to 9) for any input, legal or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_in | input | 12 | Three packed 8421 digits, hundreds in [11:8] |
| bcd_out | output | 12 | Incremented value, same packing |
| carry_out | output | 1 | Carry out of the hundreds stage |

## Verification
All 1000 legal inputs are applied, and each result is compared with decimal arithmetic on the digit values. This separates correct per-digit wrapping from a plain binary increment, which would give codes such as 0x25A. It also shows that the carry reaches exactly the digits that should change. The patterns 259, 999, 120, 009 and 099 exercise single, double and triple carry chains as well as pure pass-through. Illegal codes placed in each field, with and without an incoming carry, confirm the forced zero and the forced carry, and show how that carry moves into the next digit or out of the word.

// File: rtl/bcdinc_pkg.sv
package bcdinc_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcdinc_digit_stage.sv
module bcdinc_digit_stage
  import bcdinc_pkg::*;
(
  input  bcd_digit_t digit_i,
  input  logic       inc_i,
  output bcd_digit_t digit_o,
  output logic       carry_o
);
  logic legal_d;
  logic at_max_d;

  always_comb begin
    legal_d  = (digit_i <= bcd_digit_t'(DIGIT_MAX));
    at_max_d = (digit_i == bcd_digit_t'(DIGIT_MAX));
  end

  always_comb begin
    if (!legal_d) begin
      // illegal code: force zero and request carry
      digit_o = '0;
      carry_o = 1'b1;
    end else if (inc_i && at_max_d) begin
      digit_o = '0;
      carry_o = 1'b1;
    end else if (inc_i) begin
      digit_o = digit_i + bcd_digit_t'(1);
      carry_o = 1'b0;
    end else begin
      digit_o = digit_i;
      carry_o = 1'b0;
    end
  end
endmodule

// File: rtl/bcdinc_ripple.sv
module bcdinc_ripple
  import bcdinc_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int WORD_W    = NUM_DIGITS * DIGIT_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              carry_o
);
  logic [NUM_DIGITS:0] chain;

  assign chain[0] = 1'b1;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_stage
    bcd_digit_t d_in;
    bcd_digit_t d_out;
    assign d_in = word_i[g*DIGIT_W +: DIGIT_W];
    bcdinc_digit_stage u_stage (
      .digit_i (d_in),
      .inc_i   (chain[g]),
      .digit_o (d_out),
      .carry_o (chain[g+1])
    );
    assign word_o[g*DIGIT_W +: DIGIT_W] = d_out;
  end

  assign carry_o = chain[NUM_DIGITS];
endmodule

// File: rtl/bcdinc_word.sv
module bcdinc_word
  import bcdinc_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int WORD_W    = NUM_DIGITS * DIGIT_W
) (
  input  logic [WORD_W-1:0] bcd_in,
  output logic [WORD_W-1:0] bcd_out,
  output logic              carry_out
);
  bcdinc_ripple #(.NUM_DIGITS(NUM_DIGITS)) u_ripple (
    .word_i  (bcd_in),
    .word_o  (bcd_out),
    .carry_o (carry_out)
  );
endmodule

// File: rtl/bcdinc_word_chk.sv
module bcdinc_word_chk
  import bcdinc_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int WORD_W    = NUM_DIGITS * DIGIT_W
) (
  input logic [WORD_W-1:0] bcd_in,
  input logic [WORD_W-1:0] bcd_out,
  input logic              carry_out
);
  logic all_legal;
  logic all_max;
  logic out_legal;

  always_comb begin
    all_legal = 1'b1;
    all_max   = 1'b1;
    out_legal = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (bcd_in[i*DIGIT_W +: DIGIT_W] > bcd_digit_t'(DIGIT_MAX)) all_legal = 1'b0;
      if (bcd_in[i*DIGIT_W +: DIGIT_W] != bcd_digit_t'(DIGIT_MAX)) all_max = 1'b0;
      if (bcd_out[i*DIGIT_W +: DIGIT_W] > bcd_digit_t'(DIGIT_MAX)) out_legal = 1'b0;
    end
  end

  always_comb begin
    p_out_digits_legal_r7: assert (out_legal);
    if (all_max)
      p_full_wrap_r3: assert (carry_out && bcd_out == '0);
    if (all_legal && !all_max)
      p_no_carry_r4: assert (!carry_out);
    if (bcd_in[WORD_W-1 -: DIGIT_W] > bcd_digit_t'(DIGIT_MAX))
      p_top_illegal_carry_r6: assert (carry_out && bcd_out[WORD_W-1 -: DIGIT_W] == '0);
    if (bcd_in[DIGIT_W-1:0] < bcd_digit_t'(DIGIT_MAX))
      p_upper_pass_r5: assert (bcd_out[WORD_W-1:DIGIT_W] == bcd_in[WORD_W-1:DIGIT_W] || !all_legal);
  end
endmodule

bind bcdinc_word bcdinc_word_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .bcd_in    (bcd_in),
  .bcd_out   (bcd_out),
  .carry_out (carry_out)
);

// File: tb/bcdinc_word_tb_top.sv
module bcdinc_word_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic [11:0] bcd_in;
  logic [11:0] bcd_out;
  logic        carry_out;
  int n_checks;
  int n_fail;
  logic done;

  bcdinc_word dut_i (
    .bcd_in    (bcd_in),
    .bcd_out   (bcd_out),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [11:0] exp_w, input logic exp_c);
    n_checks++;
    if (bcd_out !== exp_w || carry_out !== exp_c) begin
      n_fail++;
      $display("FAIL %s: in=%03h actual=%03h/%0b expected=%03h/%0b",
               req, bcd_in, bcd_out, carry_out, exp_w, exp_c);
    end
  endtask

  task automatic apply(input logic [11:0] v);
    @(negedge clk);
    bcd_in = v;
    #1;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    bcd_in   = '0;
    // R1, R4: sweep of all legal inputs against decimal arithmetic
    for (int v = 0; v < 1000; v++) begin
      int nx;
      logic [11:0] enc_in, enc_ex;
      nx = (v + 1) % 1000;
      enc_in = {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
      enc_ex = {4'(nx / 100), 4'((nx / 10) % 10), 4'(nx % 10)};
      apply(enc_in);
      check(v == 999 ? "R3" : "R1_R4", enc_ex, v == 999);
    end
    apply(12'h259); check("R2", 12'h260, 1'b0);
    apply(12'h999); check("R3", 12'h000, 1'b1);
    apply(12'h120); check("R5", 12'h121, 1'b0);
    apply(12'h009); check("R5", 12'h010, 1'b0);
    apply(12'h099); check("R1", 12'h100, 1'b0);
    // R6: illegal fields force zero and carry; R7 legal outputs
    apply(12'h00A); check("R6", 12'h010, 1'b0);
    apply(12'h0A0); check("R6", 12'h101, 1'b0);
    apply(12'h0F9); check("R6", 12'h100, 1'b0);
    apply(12'hB00); check("R6", 12'h001, 1'b1);
    apply(12'hC99); check("R6", 12'h000, 1'b1);
    apply(12'hFFF); check("R7", 12'h000, 1'b1);
    apply(12'h9E5); check("R7", 12'h006, 1'b1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule